// File: doc/BRIEF.md
# Debug transport access controller

This block sits between a scan-driven debug transport and the bus that reaches a debug module. Each scan has two strobes. The capture strobe snapshots a two-bit result code and the most recent read data. These are returned to the debugger in the scan that follows. The update strobe hands over a new access word made of an address, a data value and an operation code. A read or write operation becomes one transaction on a simple request/response port. The request waits for a ready acceptance. The response returns later and carries a tag.

A scan that arrives while an access is still in flight makes the status sticky-busy. Once the status is sticky, every later scan is ignored until software writes the control word. Two recovery bits are provided there. The soft-clear bit only wipes the sticky status, so the access that is still running can finish and its result can be collected. The hard-reset bit puts the transport back to idle at once and abandons any transaction it was waiting on. A response that belongs to an abandoned transaction is recognised by its tag and thrown away.

The control word also reports several values to the debugger: the current status, a configured idle-cycle hint, the address width and a version number.

Top module: `dtm_access_ctrl`

## Requirements
- R1: After reset the captured status and captured data are 0, no request is presented, and the control word reads with both reset bits and the status field at 0.
- R2: An update with op 1 presents one read request (`req_write_o`=0) at the scanned address. The data of a successful read response is returned by the next capture, together with status 0.
- R3: An update with op 2 presents one write request (`req_write_o`=1) with the scanned address and data. Completing the write leaves the captured read data unchanged.
- R4: An update with op 0 or op 3 presents no bus request and leaves the status at 0.
- R5: A capture or update that happens while an access is outstanding returns status 3 (busy) and sets the sticky status to busy. That update presents no request.
- R6: While the sticky status is busy, every capture returns 3 and every update is ignored, even after the outstanding access completes. This lasts until a reset bit is written.
- R7: A response with its error flag set makes the sticky status 2 (failed). While it is set, captures return 2, updates present no request, and the captured read data is not updated. Status code 1 is never produced.
- R8: Writing 1 to control-word bit 16 (soft clear) sets the sticky status to 0 and does not disturb an access in flight. That access completes normally and its data is captured.
- R9: Writing 1 to control-word bit 17 (hard reset) returns the transport to idle in the next cycle, drops a pending request, and clears the sticky status. If both bits are written together, the hard reset applies.
- R10: After a hard reset, a response whose tag does not match the current transaction's tag is discarded: it changes neither the captured data nor the state. Each new request carries a tag that differs from the previous one.
- R11: The control word reads as follows: bits [3:0] hold the version, [9:4] the address width, [11:10] the sticky status, [14:12] the idle-cycle hint, and bits 17 and 16 always read 0.
- R12: A presented request keeps `req_valid_o` high and holds its address, data and direction stable until `req_ready_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_cap_i | input | 1 | Capture strobe: snapshot status and read data |
| scan_upd_i | input | 1 | Update strobe: accept a new access word |
| scan_op_i | input | 2 | Operation: 0 none, 1 read, 2 write, 3 none |
| scan_addr_i | input | ADDR_W | Access address |
| scan_data_i | input | DATA_W | Access write data |
| cap_status_o | output | 2 | Status code captured for the debugger |
| cap_data_o | output | DATA_W | Read data captured for the debugger |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data (bits 17 and 16 act) |
| ctl_rdata_o | output | 32 | Control word read value |
| req_valid_o | output | 1 | Bus request valid |
| req_ready_i | input | 1 | Bus request accepted |
| req_write_o | output | 1 | Request is a write |
| req_addr_o | output | ADDR_W | Request address |
| req_data_o | output | DATA_W | Request write data |
| req_tag_o | output | TAG_W | Transaction tag |
| rsp_valid_i | input | 1 | Response valid |
| rsp_tag_i | input | TAG_W | Tag of the response |
| rsp_err_i | input | 1 | Response reports failure |
| rsp_data_i | input | DATA_W | Response read data |

## Verification
The bench builds the block with a 6-bit address, 32-bit data, a 2-bit tag and an idle hint of 5. These give a control word with a known layout (0x5061 at rest), so the packed status, hint and width fields can be checked as a whole value. The short tag means a single hard reset followed by one new request is enough to show a stale response with the old tag being rejected while the new tag is accepted. The bench also holds `req_ready_i` low for several cycles so that request stability can be observed.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_RSVD = 2'd1,
        ST_FAIL = 2'd2,
        ST_BUSY = 2'd3
    } scan_stat_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2,
        OP_RSVD = 2'd3
    } scan_op_e;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_ISSUE = 2'd1,
        BUS_WAIT  = 2'd2
    } bus_st_e;

    localparam int CTL_W       = 32;
    localparam int HARD_BIT    = 17;
    localparam int SOFT_BIT    = 16;
    localparam int HINT_LSB    = 12;
    localparam int HINT_W      = 3;
    localparam int STAT_LSB    = 10;
    localparam int WIDTH_LSB   = 4;
    localparam int WIDTH_W     = 6;
    localparam int VER_W       = 4;

endpackage

// File: rtl/dtm_ctl_word.sv
module dtm_ctl_word
    import dtm_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int IDLE_HINT = 3,
    parameter int VERSION   = 1
) (
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    input  logic [1:0]       sticky_i,
    output logic             soft_clr_o,
    output logic             hard_clr_o,
    output logic [CTL_W-1:0] ctl_rdata_o
);

    localparam logic [HINT_W-1:0]  HINT_V  = HINT_W'(IDLE_HINT);
    localparam logic [WIDTH_W-1:0] WIDTH_V = WIDTH_W'(ADDR_W);
    localparam logic [VER_W-1:0]   VER_V   = VER_W'(VERSION);

    logic unused_wbits;
    assign unused_wbits = ^{ctl_wdata_i[CTL_W-1:HARD_BIT+1], ctl_wdata_i[SOFT_BIT-1:0]};

    always_comb begin
        hard_clr_o  = ctl_wr_i && ctl_wdata_i[HARD_BIT];
        soft_clr_o  = ctl_wr_i && ctl_wdata_i[SOFT_BIT] && !ctl_wdata_i[HARD_BIT];
        ctl_rdata_o = '0;
        ctl_rdata_o[HINT_LSB +: HINT_W]   = HINT_V;
        ctl_rdata_o[STAT_LSB +: 2]        = sticky_i;
        ctl_rdata_o[WIDTH_LSB +: WIDTH_W] = WIDTH_V;
        ctl_rdata_o[0 +: VER_W]           = VER_V;
    end

endmodule

// File: rtl/dtm_status.sv
module dtm_status
    import dtm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              upd_i,
    input  logic [1:0]        op_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              done_err_i,
    input  logic              soft_clr_i,
    input  logic              hard_clr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              launch_o,
    output logic [1:0]        sticky_o,
    output logic [1:0]        cap_status_o,
    output logic [DATA_W-1:0] cap_data_o
);

    typedef struct packed {
        scan_stat_e        sticky;
        scan_stat_e        cap_status;
        logic [DATA_W-1:0] cap_data;
    } stat_regs_t;

    stat_regs_t q, d;
    logic       clean;
    logic       clr;

    always_comb begin
        d        = q;
        clean    = (q.sticky == ST_OK);
        clr      = soft_clr_i || hard_clr_i;
        launch_o = upd_i && clean && !busy_i && !clr &&
                   ((op_i == OP_RD) || (op_i == OP_WR));

        if (clr) begin
            d.sticky = ST_OK;
        end else if (clean) begin
            if ((cap_i || upd_i) && busy_i) begin
                d.sticky = ST_BUSY;
            end else if (done_i && done_err_i) begin
                d.sticky = ST_FAIL;
            end
        end

        if (cap_i) begin
            d.cap_status = !clean ? q.sticky : (busy_i ? ST_BUSY : ST_OK);
            d.cap_data   = rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sticky     <= ST_OK;
            q.cap_status <= ST_OK;
            q.cap_data   <= '0;
        end else begin
            q <= d;
        end
    end

    assign sticky_o     = q.sticky;
    assign cap_status_o = q.cap_status;
    assign cap_data_o   = q.cap_data;

    // R6: a busy status survives until a clear arrives
    p_busy_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sticky == ST_BUSY && !soft_clr_i && !hard_clr_i) |=> (q.sticky == ST_BUSY));

    // R7: failed status is sticky too
    p_fail_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sticky == ST_FAIL && !soft_clr_i && !hard_clr_i) |=> (q.sticky == ST_FAIL));

    // R7: reserved code never appears on the captured status
    p_no_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cap_status != ST_RSVD);

    // R8/R9: a clear always leaves the status clean
    p_clear_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr_i || hard_clr_i) |=> (q.sticky == ST_OK));

endmodule

// File: rtl/dtm_bus_fsm.sv
module dtm_bus_fsm
    import dtm_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              launch_wr_i,
    input  logic [ADDR_W-1:0] launch_addr_i,
    input  logic [DATA_W-1:0] launch_data_i,
    input  logic              hard_clr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              done_err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_data_o,
    output logic [TAG_W-1:0]  req_tag_o,
    input  logic              rsp_valid_i,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    input  logic              rsp_err_i,
    input  logic [DATA_W-1:0] rsp_data_i
);

    typedef struct packed {
        bus_st_e           st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] rdata;
    } bus_regs_t;

    bus_regs_t q, d;
    logic      tag_hit;

    always_comb begin
        d          = q;
        done_o     = 1'b0;
        done_err_o = 1'b0;
        tag_hit    = rsp_valid_i && (rsp_tag_i == q.tag);

        case (q.st)
            BUS_IDLE: begin
                if (launch_i) begin
                    d.st   = BUS_ISSUE;
                    d.wr   = launch_wr_i;
                    d.addr = launch_addr_i;
                    d.data = launch_data_i;
                    d.tag  = q.tag + 1'b1;
                end
            end
            BUS_ISSUE: begin
                if (req_ready_i) d.st = BUS_WAIT;
            end
            BUS_WAIT: begin
                if (tag_hit) begin
                    d.st       = BUS_IDLE;
                    done_o     = 1'b1;
                    done_err_o = rsp_err_i;
                    if (!rsp_err_i && !q.wr) d.rdata = rsp_data_i;
                end
            end
            default: d.st = BUS_IDLE;
        endcase

        if (hard_clr_i) begin
            d.st       = BUS_IDLE;
            d.rdata    = q.rdata;
            done_o     = 1'b0;
            done_err_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= BUS_IDLE;
            q.wr    <= 1'b0;
            q.addr  <= '0;
            q.data  <= '0;
            q.tag   <= '0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != BUS_IDLE);
    assign rdata_o     = q.rdata;
    assign req_valid_o = (q.st == BUS_ISSUE);
    assign req_write_o = q.wr;
    assign req_addr_o  = q.addr;
    assign req_data_o  = q.data;
    assign req_tag_o   = q.tag;

    // R12: request payload held until accepted
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && !hard_clr_i) |=>
        (req_valid_o && $stable(req_addr_o) && $stable(req_data_o) && $stable(req_write_o)));

    // R5: a new access only starts from idle
    p_launch_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> (q.st == BUS_IDLE));

    // R9: hard reset leaves nothing outstanding
    p_hard_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr_i |=> (!busy_o && !req_valid_o));

    // R10: a response with a foreign tag never touches read data
    p_stale_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_tag_i != q.tag) |=> $stable(rdata_o));

endmodule

// File: rtl/dtm_access_ctrl.sv
module dtm_access_ctrl
    import dtm_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 2,
    parameter int IDLE_HINT = 3,
    parameter int VERSION   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_cap_i,
    input  logic              scan_upd_i,
    input  logic [1:0]        scan_op_i,
    input  logic [ADDR_W-1:0] scan_addr_i,
    input  logic [DATA_W-1:0] scan_data_i,
    output logic [1:0]        cap_status_o,
    output logic [DATA_W-1:0] cap_data_o,
    input  logic              ctl_wr_i,
    input  logic [31:0]       ctl_wdata_i,
    output logic [31:0]       ctl_rdata_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_data_o,
    output logic [TAG_W-1:0]  req_tag_o,
    input  logic              rsp_valid_i,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    input  logic              rsp_err_i,
    input  logic [DATA_W-1:0] rsp_data_i
);

    logic              soft_clr, hard_clr;
    logic [1:0]        sticky;
    logic              launch, busy, done, done_err;
    logic [DATA_W-1:0] rdata;

    dtm_ctl_word #(
        .ADDR_W    (ADDR_W),
        .IDLE_HINT (IDLE_HINT),
        .VERSION   (VERSION)
    ) u_ctl (
        .ctl_wr_i    (ctl_wr_i),
        .ctl_wdata_i (ctl_wdata_i),
        .sticky_i    (sticky),
        .soft_clr_o  (soft_clr),
        .hard_clr_o  (hard_clr),
        .ctl_rdata_o (ctl_rdata_o)
    );

    dtm_status #(
        .DATA_W (DATA_W)
    ) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_i        (scan_cap_i),
        .upd_i        (scan_upd_i),
        .op_i         (scan_op_i),
        .busy_i       (busy),
        .done_i       (done),
        .done_err_i   (done_err),
        .soft_clr_i   (soft_clr),
        .hard_clr_i   (hard_clr),
        .rdata_i      (rdata),
        .launch_o     (launch),
        .sticky_o     (sticky),
        .cap_status_o (cap_status_o),
        .cap_data_o   (cap_data_o)
    );

    dtm_bus_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch_i      (launch),
        .launch_wr_i   (scan_op_i == OP_WR),
        .launch_addr_i (scan_addr_i),
        .launch_data_i (scan_data_i),
        .hard_clr_i    (hard_clr),
        .busy_o        (busy),
        .done_o        (done),
        .done_err_o    (done_err),
        .rdata_o       (rdata),
        .req_valid_o   (req_valid_o),
        .req_ready_i   (req_ready_i),
        .req_write_o   (req_write_o),
        .req_addr_o    (req_addr_o),
        .req_data_o    (req_data_o),
        .req_tag_o     (req_tag_o),
        .rsp_valid_i   (rsp_valid_i),
        .rsp_tag_i     (rsp_tag_i),
        .rsp_err_i     (rsp_err_i),
        .rsp_data_i    (rsp_data_i)
    );

    // R4: a none/reserved update never starts a request
    p_nop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_upd_i && (scan_op_i == OP_NONE || scan_op_i == OP_RSVD) && !req_valid_o)
        |=> !req_valid_o);

endmodule

// File: tb/sim_dtm_access_ctrl.sv
module sim_dtm_access_ctrl;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_cap = 1'b0, scan_upd = 1'b0;
    logic [1:0]    scan_op = '0;
    logic [AW-1:0] scan_addr = '0;
    logic [DW-1:0] scan_data = '0;
    logic [1:0]    cap_status;
    logic [DW-1:0] cap_data;
    logic          ctl_wr = 1'b0;
    logic [31:0]   ctl_wdata = '0;
    logic [31:0]   ctl_rdata;
    logic          req_valid, req_ready = 1'b0, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [TW-1:0] req_tag;
    logic          rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [DW-1:0] rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_rd = '0;

    always #2 clk = ~clk;

    dtm_access_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .IDLE_HINT(5), .VERSION(1)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .scan_cap_i(scan_cap), .scan_upd_i(scan_upd), .scan_op_i(scan_op),
        .scan_addr_i(scan_addr), .scan_data_i(scan_data),
        .cap_status_o(cap_status), .cap_data_o(cap_data),
        .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
        .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
        .req_addr_o(req_addr), .req_data_o(req_data), .req_tag_o(req_tag),
        .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag), .rsp_err_i(rsp_err),
        .rsp_data_i(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic scan(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] dat, output logic [1:0] st,
                        output logic [DW-1:0] rd);
        scan_cap = 1'b1;
        step();
        scan_cap = 1'b0;
        st = cap_status;
        rd = cap_data;
        scan_upd = 1'b1; scan_op = op; scan_addr = a; scan_data = dat;
        step();
        scan_upd = 1'b0; scan_op = 2'd0;
    endtask

    task automatic ctl_write(input logic [31:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step();
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic accept(input int hold, output logic [TW-1:0] tg,
                          output logic [AW-1:0] a, output logic w,
                          output logic [DW-1:0] dat);
        int waited = 0;
        while (!req_valid && waited < 40) begin
            step();
            waited++;
        end
        chk(req_valid, "R2 request seen", 32'(req_valid), 32'd1);
        tg = req_tag; a = req_addr; w = req_write; dat = req_data;
        for (int i = 0; i < hold; i++) begin
            step();
            chk(req_valid && req_addr == a && req_data == dat && req_write == w,
                "R12 request held", 32'(req_addr), 32'(a));
        end
        req_ready = 1'b1;
        step();
        req_ready = 1'b0;
    endtask

    task automatic respond(input logic [TW-1:0] tg, input logic [DW-1:0] dat,
                           input logic e);
        rsp_valid = 1'b1; rsp_tag = tg; rsp_data = dat; rsp_err = e;
        step();
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic no_req(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            if (req_valid) seen = 1'b1;
        end
        chk(!seen, req, 32'(seen), 32'd0);
    endtask

    task automatic t_reset();
        chk(cap_status == 2'd0, "R1 status", 32'(cap_status), 0);
        chk(cap_data == '0, "R1 data", cap_data, 0);
        chk(!req_valid, "R1 no request", 32'(req_valid), 0);
        chk(ctl_rdata == 32'h5061, "R1 R11 control word", ctl_rdata, 32'h5061);
    endtask

    task automatic t_read();
        logic [1:0] st; logic [DW-1:0] rd; logic [TW-1:0] tg;
        logic [AW-1:0] a; logic w; logic [DW-1:0] dd;
        scan(2'd1, 6'h11, '0, st, rd);
        chk(st == 2'd0, "R2 capture clean", 32'(st), 0);
        accept(0, tg, a, w, dd);
        chk(a == 6'h11 && !w, "R2 read address", 32'(a), 32'h11);
        repeat (2) step();
        respond(tg, 32'hA5A5_0001, 1'b0);
        exp_rd = 32'hA5A5_0001;
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0, "R2 status ok", 32'(st), 0);
        chk(rd == exp_rd, "R2 read data", rd, exp_rd);
        no_req(4, "R4 op 0 issues nothing");
    endtask

    task automatic t_write();
        logic [1:0] st; logic [DW-1:0] rd; logic [TW-1:0] tg;
        logic [AW-1:0] a; logic w; logic [DW-1:0] dd;
        scan(2'd2, 6'h22, 32'hDEAD_BEEF, st, rd);
        accept(3, tg, a, w, dd);
        chk(w && a == 6'h22, "R3 write direction/address", {31'd0, w}, 1);
        chk(dd == 32'hDEAD_BEEF, "R3 write data", dd, 32'hDEAD_BEEF);
        respond(tg, 32'h0BAD_0BAD, 1'b0);
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0, "R3 status ok", 32'(st), 0);
        chk(rd == exp_rd, "R3 read data kept", rd, exp_rd);
    endtask

    task automatic t_rsvd_op();
        logic [1:0] st; logic [DW-1:0] rd;
        scan(2'd3, 6'h33, 32'h1, st, rd);
        no_req(5, "R4 op 3 issues nothing");
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0, "R4 status stays 0", 32'(st), 0);
    endtask

    task automatic t_busy();
        logic [1:0] st; logic [DW-1:0] rd; logic [TW-1:0] tg;
        logic [AW-1:0] a; logic w; logic [DW-1:0] dd;
        scan(2'd1, 6'h05, '0, st, rd);
        accept(0, tg, a, w, dd);
        scan(2'd1, 6'h06, '0, st, rd);
        chk(st == 2'd3, "R5 busy returned", 32'(st), 3);
        respond(tg, 32'h1111_2222, 1'b0);
        exp_rd = 32'h1111_2222;
        no_req(3, "R5 busy update dropped");
        scan(2'd1, 6'h07, '0, st, rd);
        chk(st == 2'd3, "R6 busy persists", 32'(st), 3);
        no_req(4, "R6 update ignored");
        chk(ctl_rdata[11:10] == 2'd3, "R11 status field busy", 32'(ctl_rdata[11:10]), 3);
        ctl_write(32'h0001_0000);
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0, "R8 soft clear", 32'(st), 0);
        chk(rd == exp_rd, "R8 earlier data collected", rd, exp_rd);
    endtask

    task automatic t_soft_inflight();
        logic [1:0] st; logic [DW-1:0] rd; logic [TW-1:0] tg;
        logic [AW-1:0] a; logic w; logic [DW-1:0] dd;
        scan(2'd1, 6'h08, '0, st, rd);
        accept(0, tg, a, w, dd);
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd3, "R5 busy in flight", 32'(st), 3);
        ctl_write(32'h0001_0000);
        respond(tg, 32'h0808_0808, 1'b0);
        exp_rd = 32'h0808_0808;
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0, "R8 in-flight status", 32'(st), 0);
        chk(rd == exp_rd, "R8 in-flight completes", rd, exp_rd);
    endtask

    task automatic t_err();
        logic [1:0] st; logic [DW-1:0] rd; logic [TW-1:0] tg;
        logic [AW-1:0] a; logic w; logic [DW-1:0] dd;
        scan(2'd1, 6'h09, '0, st, rd);
        accept(0, tg, a, w, dd);
        respond(tg, 32'hEEEE_EEEE, 1'b1);
        scan(2'd2, 6'h0A, 32'h5, st, rd);
        chk(st == 2'd2, "R7 failed status", 32'(st), 2);
        no_req(4, "R7 update ignored");
        chk(ctl_rdata == 32'h5861, "R11 control word failed", ctl_rdata, 32'h5861);
        ctl_write(32'h0001_0000);
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0, "R7 cleared", 32'(st), 0);
        chk(rd == exp_rd, "R7 data untouched", rd, exp_rd);
    endtask

    task automatic t_hard();
        logic [1:0] st; logic [DW-1:0] rd; logic [TW-1:0] t_old, t_new;
        logic [AW-1:0] a; logic w; logic [DW-1:0] dd;
        scan(2'd1, 6'h0B, '0, st, rd);
        accept(0, t_old, a, w, dd);
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd3, "R5 busy before hard reset", 32'(st), 3);
        ctl_write(32'h0003_0000);
        chk(ctl_rdata == 32'h5061, "R9 R11 control word after hard", ctl_rdata, 32'h5061);
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0, "R9 idle after hard", 32'(st), 0);
        respond(t_old, 32'hBAD0_BAD0, 1'b0);
        scan(2'd0, '0, '0, st, rd);
        chk(rd == exp_rd, "R10 late response dropped", rd, exp_rd);
        scan(2'd1, 6'h0C, '0, st, rd);
        accept(0, t_new, a, w, dd);
        chk(t_new != t_old, "R10 fresh tag", 32'(t_new), 32'(t_old) ^ 1);
        respond(t_old, 32'hBAD1_BAD1, 1'b0);
        respond(t_new, 32'h0C0C_0C0C, 1'b0);
        exp_rd = 32'h0C0C_0C0C;
        scan(2'd0, '0, '0, st, rd);
        chk(st == 2'd0 && rd == exp_rd, "R10 matching tag accepted", rd, exp_rd);
    endtask

    task automatic t_hard_issue();
        logic [1:0] st; logic [DW-1:0] rd;
        scan(2'd1, 6'h0D, '0, st, rd);
        chk(req_valid, "R9 request pending", 32'(req_valid), 1);
        ctl_write(32'h0002_0000);
        chk(!req_valid, "R9 request dropped", 32'(req_valid), 0);
        no_req(3, "R9 stays idle");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_read();
        t_write();
        t_rsvd_op();
        t_busy();
        t_soft_inflight();
        t_err();
        t_hard();
        t_hard_issue();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule